// File: doc/BRIEF.md
# Host Image Download Loader

This block takes a firmware image that a host streams in one byte at a time and writes it into on-chip memory. A qualifier input marks page bytes. A marked byte selects a 128-byte chunk of memory and restarts the offset within that chunk. Unmarked bytes that follow it are written to consecutive locations in the chunk. The host can therefore break a download at any chunk boundary and resume anywhere by sending a new marked byte.

Every stored byte is added into a 32-bit checksum. The host reads this checksum to confirm the image before it goes on. The host also programs a 32-bit start address as two 16-bit halves. It then writes a flags location, which starts the loaded program. The start is refused unless both halves of the address were written first. A chunk that receives more bytes than fit into it latches an error and freezes the loader until reset.

Top module: `img_loader`

## Requirements
- R1: After reset, `mem_we`, `launch` and `ovr_err` are 0, the checksum at register 0xFF reads 0, and both address halves (0x18, 0x19) read 0.
- R2: A byte with `in_qual` high selects page `in_byte[PAGE_W-1:0]` and resets the chunk offset to 0. The marked byte itself is neither written nor summed.
- R3: A byte with `in_qual` low is written to `mem_addr = {page, offset}` with `mem_we` high in the cycle after it is presented. The offset then advances by one.
- R4: Unmarked bytes that arrive before the first marked byte since reset are discarded. They cause no write and no checksum change.
- R5: An unmarked byte that arrives when the chunk already holds 128 bytes sets `ovr_err`. That byte is dropped. `ovr_err` stays high until reset, and every later byte, marked or not, is ignored.
- R6: The checksum is the wrapping 32-bit sum of little-endian words. A byte stored at chunk offset o adds `byte << (8*(o mod 4))`. The new value is readable at register 0xFF in the cycle after the byte.
- R7: Host writes to register 0xFF leave the checksum unchanged.
- R8: Registers 0x18 (bits 31:16) and 0x19 (bits 15:0) are writable and read back the written value, zero-extended to 32 bits. `entry_addr` always shows the concatenation of the two halves.
- R9: A write to the flags register 0x1A raises `launch` for exactly the next cycle, but only if both 0x18 and 0x19 have been written since reset. Otherwise `launch` stays low.
- R10: A chunk of exactly 128 unmarked bytes is stored completely, and `ovr_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the serial host |
| in_byte | input | 8 | Received byte |
| in_qual | input | 1 | Marks the byte as a page select |
| reg_wr | input | 1 | Host register write |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 16 | Host register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PAGE_W+7 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| ovr_err | output | 1 | Sticky chunk overrun |
| entry_addr | output | 32 | Program start address |
| launch | output | 1 | One-cycle start pulse |

## Verification
The hardest case to reach is the overrun. It needs exactly 128 accepted bytes followed by one more unmarked byte, and the loader must stay frozen after that. The bench fills one chunk to exactly 128 bytes and checks that no error appears. It then refills another chunk and sends a 129th byte, followed by a marked byte and more data. A scoreboard of expected writes checks that nothing further reaches memory, and a readback checks that the checksum stayed the same. Before the overrun test, the bench computes a final aligned word so that the checksum lands on 0xAA55AA55. This exercises all four byte lanes and the wraparound.

// File: rtl/img_loader.sv
module img_loader #(
  parameter int PAGE_W = 8,
  parameter int CHUNK = 128,
  parameter logic [7:0] HI_ADDR = 8'h18,
  parameter logic [7:0] LO_ADDR = 8'h19,
  parameter logic [7:0] FLAG_ADDR = 8'h1A,
  parameter logic [7:0] SUM_ADDR = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic [7:0] in_byte,
  input  logic in_qual,
  input  logic reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic mem_we,
  output logic [PAGE_W+$clog2(CHUNK)-1:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic ovr_err,
  output logic [31:0] entry_addr,
  output logic launch
);
  localparam int OFF_W = $clog2(CHUNK);
  localparam logic [OFF_W:0] FULL = CHUNK[OFF_W:0];

  logic [PAGE_W-1:0] page;
  logic [OFF_W:0] cnt;
  logic have_page;
  logic [31:0] sum;
  logic [15:0] ent_hi, ent_lo;
  logic hi_set, lo_set;

  wire take_q = in_valid & in_qual & ~ovr_err;
  wire is_data = in_valid & ~in_qual & have_page & ~ovr_err;
  wire room = cnt != FULL;
  wire take_d = is_data & room;
  wire [31:0] lane = {24'b0, in_byte} << {cnt[1:0], 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
      cnt <= '0;
      have_page <= 1'b0;
      sum <= '0;
      mem_we <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
      ovr_err <= 1'b0;
    end else begin
      mem_we <= take_d;
      if (take_d) begin
        mem_addr <= {page, cnt[OFF_W-1:0]};
        mem_wdata <= in_byte;
        cnt <= cnt + 1'b1;
        sum <= sum + lane;
      end
      if (take_q) begin
        page <= in_byte[PAGE_W-1:0];
        cnt <= '0;
        have_page <= 1'b1;
      end
      if (is_data && !room) ovr_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_hi <= '0;
      ent_lo <= '0;
      hi_set <= 1'b0;
      lo_set <= 1'b0;
      launch <= 1'b0;
    end else begin
      launch <= reg_wr && reg_addr == FLAG_ADDR && hi_set && lo_set;
      if (reg_wr && reg_addr == HI_ADDR) begin
        ent_hi <= reg_wdata;
        hi_set <= 1'b1;
      end
      if (reg_wr && reg_addr == LO_ADDR) begin
        ent_lo <= reg_wdata;
        lo_set <= 1'b1;
      end
    end
  end

  assign entry_addr = {ent_hi, ent_lo};

  always_comb begin
    case (reg_addr)
      HI_ADDR:  reg_rdata = {16'b0, ent_hi};
      LO_ADDR:  reg_rdata = {16'b0, ent_lo};
      SUM_ADDR: reg_rdata = sum;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/img_loader_chk.sv
module img_loader_chk #(
  parameter logic [7:0] FLAG_ADDR = 8'h1A
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_qual,
  input logic reg_wr,
  input logic [7:0] reg_addr,
  input logic mem_we,
  input logic ovr_err,
  input logic launch,
  input logic [31:0] sum
);
  // R3
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && !in_qual));
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);
  // R5
  ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> !mem_we);
  // R9
  launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(reg_wr && reg_addr == FLAG_ADDR));
  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(sum));
endmodule

bind img_loader img_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_qual(in_qual),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .mem_we(mem_we),
  .ovr_err(ovr_err), .launch(launch), .sum(sum)
);

// File: tb/img_loader_test.sv
module img_loader_test;
  localparam int AW = 15;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_qual = 0, reg_wr = 0;
  logic [7:0] in_byte = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [31:0] reg_rdata, entry_addr;
  logic mem_we, ovr_err, launch;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0, fails = 0;
  logic [AW+7:0] expq[$];
  logic [7:0] m_page = 0;
  int m_cnt = 0;
  bit m_have = 0, m_err = 0;
  logic [31:0] m_sum = 0;

  img_loader uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_we) begin
    if (expq.size() == 0) chk(0, "R3/R4/R5 unexpected write", {9'b0, mem_addr, mem_wdata}, 0);
    else begin
      logic [AW+7:0] e;
      e = expq.pop_front();
      chk({mem_addr, mem_wdata} == e, "R3 write", {9'b0, mem_addr, mem_wdata}, {9'b0, e});
    end
  end

  task automatic send(input logic [7:0] b, input bit q);
    @(negedge clk);
    in_valid = 1; in_byte = b; in_qual = q;
    if (!m_err) begin
      if (q) begin m_page = b; m_cnt = 0; m_have = 1; end
      else if (m_have) begin
        if (m_cnt == 128) m_err = 1;
        else begin
          expq.push_back({m_page, m_cnt[6:0], b});
          m_sum += {24'b0, b} << (8 * (m_cnt % 4));
          m_cnt++;
        end
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_qual = 0; reg_wr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, w, s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!mem_we && !launch && !ovr_err, "R1 outputs", {mem_we, launch, ovr_err}, 0);
    rd(8'hFF, d); chk(d == 0, "R1 checksum", d, 0);
    rd(8'h18, d); chk(d == 0, "R1 entry hi", d, 0);
    // R4
    send(8'h11, 0); send(8'h22, 0); idle(); idle();
    rd(8'hFF, d); chk(d == 0, "R4 stray bytes", d, 0);
    // R2 R3 R6
    send(8'h03, 1);
    for (int i = 0; i < 9; i++) send(8'h30 + i[7:0], 0);
    idle(); idle();
    rd(8'hFF, d); chk(d == m_sum, "R6 checksum page 3", d, m_sum);
    send(8'h05, 1);
    for (int i = 0; i < 128; i++) send(i[7:0] * 8'd7 + 8'd1, 0);
    idle(); idle();
    // R10
    chk(!ovr_err, "R10 full chunk no error", ovr_err, 0);
    rd(8'hFF, d); chk(d == m_sum, "R6 checksum full chunk", d, m_sum);
    // R2 page switch restarts offset
    send(8'h03, 1); send(8'hA5, 0); idle(); idle();
    // R7
    s0 = m_sum;
    wr(8'hFF, 16'h1234);
    rd(8'hFF, d); chk(d == s0, "R7 checksum read-only", d, s0);
    // R9 launch refused
    wr(8'h1A, 16'h0001);
    chk(!launch, "R9 no launch without address", launch, 0);
    wr(8'h18, 16'hBEEF);
    wr(8'h1A, 16'h0001);
    chk(!launch, "R9 no launch with half address", launch, 0);
    wr(8'h19, 16'hC0DE);
    // R8
    rd(8'h18, d); chk(d == 32'h0000BEEF, "R8 hi readback", d, 32'h0000BEEF);
    rd(8'h19, d); chk(d == 32'h0000C0DE, "R8 lo readback", d, 32'h0000C0DE);
    chk(entry_addr == 32'hBEEFC0DE, "R8 entry_addr", entry_addr, 32'hBEEFC0DE);
    // R9 launch
    wr(8'h1A, 16'h0001);
    chk(launch, "R9 launch pulse", launch, 1);
    @(negedge clk);
    chk(!launch, "R9 launch one cycle", launch, 0);
    // R6 target checksum
    w = 32'hAA55AA55 - m_sum;
    send(8'h0A, 1);
    send(w[7:0], 0); send(w[15:8], 0); send(w[23:16], 0); send(w[31:24], 0);
    idle(); idle();
    rd(8'hFF, d); chk(d == 32'hAA55AA55, "R6 image checksum", d, 32'hAA55AA55);
    // R5 overrun
    send(8'h07, 1);
    for (int i = 0; i < 128; i++) send(8'hFF - i[7:0], 0);
    idle(); idle();
    chk(!ovr_err, "R10 no early error", ovr_err, 0);
    s0 = m_sum;
    send(8'h99, 0); idle(); idle();
    chk(ovr_err, "R5 overrun flag", ovr_err, 1);
    send(8'h09, 1); send(8'h44, 0); send(8'h55, 0); idle(); idle(); idle();
    chk(ovr_err, "R5 sticky", ovr_err, 1);
    rd(8'hFF, d); chk(d == s0, "R5 checksum frozen", d, s0);
    chk(expq.size() == 0, "R3 all writes seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule